// File: doc/BRIEF.md
# Prescaled Timer Down-Counter

An 8-bit down-counter that a processor core uses as an interval timer. Software presets it with a load command and starts it with a start command. While it runs, a fixed divide-by-32 prescaler counts machine-cycle strobes, and every 32nd strobe takes one off the count. At a 4 MHz clock one decrement is 64 us, so a run from 255 lasts a little over 16 ms.

A get command copies the live count to the output without stopping or changing the counter. When the count would step from 1 to 0, the counter takes back the last loaded value and raises a sticky underflow flag, so the timer gives periodic interrupts. The interrupt request is that flag gated by an enable latch. The latch is set and cleared by its own command strobes. A stop command, or reset, halts counting and clears the flag.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset, count_out is 0, irq_req is 0, the counter is idle and the interrupt enable is cleared.
- R2: A load_stb cycle sets both the count and the reload value to load_val at that clock edge. It takes priority over a decrement in the same cycle.
- R3: A start_stb cycle puts the counter in the running state and clears the prescaler, so the first decrement happens on exactly the 32nd strobe that follows.
- R4: While running, the count drops by one on every 32nd cycle with cyc_stb high. Cycles with cyc_stb low do not advance the prescaler.
- R5: A get_stb cycle loads count_out with the count held before that edge, and count_out is valid from the next cycle. Otherwise count_out holds its value, and a get never alters the count.
- R6: When a decrement falls on a count of 1, the count becomes the reload value in place of 0. The underflow flag is set and counting continues.
- R7: irq_req is the underflow flag ANDed with the enable latch. irq_en_set sets the latch and irq_en_clr clears it, and the clear wins when both are high. A cleared latch masks the request but does not stop counting.
- R8: stop_stb halts counting and clears the underflow flag. It takes priority over start_stb in the same cycle.
- R9: A load while running changes the count at once but keeps the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | Machine-cycle strobe, one cycle wide |
| load_stb | input | 1 | Load command |
| start_stb | input | 1 | Start (timer mode) command |
| stop_stb | input | 1 | Stop command |
| get_stb | input | 1 | Get command |
| load_val | input | 8 | Value written by load |
| irq_en_set | input | 1 | Set interrupt enable |
| irq_en_clr | input | 1 | Clear interrupt enable |
| count_out | output | 8 | Count captured by the last get |
| irq_req | output | 1 | Underflow interrupt request |

## Verification
The assertions assume that every command input is a single-cycle pulse sampled on the rising edge. They also assume that load_val is stable in any cycle where load_stb is high. They make no assumption about how commands overlap. The priority checks (load over decrement, stop over start, clear over set) are written to hold under any overlap. The stimulus drives all inputs away from the active edge and raises each strobe for exactly one cycle. It keeps cyc_stb low during command cycles, so that the expected prescaler phase can be counted from the requirements alone.

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer #(
  parameter int W   = 8,
  parameter int DIV = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cyc_stb,
  input  logic         load_stb,
  input  logic         start_stb,
  input  logic         stop_stb,
  input  logic         get_stb,
  input  logic [W-1:0] load_val,
  input  logic         irq_en_set,
  input  logic         irq_en_clr,
  output logic [W-1:0] count_out,
  output logic         irq_req
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DIV - 1);

  logic [W-1:0]  cnt, rld;
  logic [PW-1:0] presc;
  logic          running, uflag, ien;
  logic          tick;

  assign tick    = running && cyc_stb && (presc == PLAST);
  assign irq_req = uflag && ien;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc   <= '0;
      running <= 1'b0;
    end else if (stop_stb) begin
      running <= 1'b0;
    end else if (start_stb) begin
      running <= 1'b1;
      presc   <= '0;
    end else if (running && cyc_stb) begin
      presc <= tick ? '0 : presc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      rld <= '0;
    end else if (load_stb) begin
      cnt <= load_val;
      rld <= load_val;
    end else if (tick && !stop_stb && !start_stb) begin
      cnt <= (cnt <= W'(1)) ? rld : cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stop_stb)
      uflag <= 1'b0;
    else if (tick && !start_stb && !load_stb && cnt == W'(1))
      uflag <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          ien <= 1'b0;
    else if (irq_en_clr) ien <= 1'b0;
    else if (irq_en_set) ien <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count_out <= '0;
    else if (get_stb) count_out <= cnt;
  end
endmodule

// File: rtl/prescaled_down_timer_chk.sv
module prescaled_down_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cyc_stb,
  input logic         load_stb,
  input logic         stop_stb,
  input logic         get_stb,
  input logic         irq_en_clr,
  input logic [W-1:0] load_val,
  input logic [W-1:0] cnt,
  input logic [W-1:0] count_out,
  input logic         uflag,
  input logic         irq_req
);
  // R2
  load_takes_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> cnt == $past(load_val));

  // R4
  no_strobe_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_stb && !cyc_stb) |=> $stable(cnt));

  // R5
  out_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !get_stb |=> $stable(count_out));

  // R6
  flag_from_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uflag) |-> $past(cnt) == W'(1));

  // R7
  disable_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en_clr |=> !irq_req);

  // R8
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_stb |=> !uflag && !irq_req);
endmodule

bind prescaled_down_timer prescaled_down_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .load_stb(load_stb),
  .stop_stb(stop_stb), .get_stb(get_stb), .irq_en_clr(irq_en_clr),
  .load_val(load_val), .cnt(cnt), .count_out(count_out),
  .uflag(uflag), .irq_req(irq_req)
);

// File: tb/tb_prescaled_down_timer.sv
module tb_prescaled_down_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_stb = 1'b0, load_stb = 1'b0, start_stb = 1'b0, stop_stb = 1'b0;
  logic       get_stb = 1'b0, irq_en_set = 1'b0, irq_en_clr = 1'b0;
  logic [7:0] load_val = '0;
  logic [7:0] count_out;
  logic       irq_req;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       get_seen = 1'b0;
  logic       done = 1'b0;

  prescaled_down_timer dut (
    .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .load_stb(load_stb),
    .start_stb(start_stb), .stop_stb(stop_stb), .get_stb(get_stb),
    .load_val(load_val), .irq_en_set(irq_en_set), .irq_en_clr(irq_en_clr),
    .count_out(count_out), .irq_req(irq_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) get_seen <= get_stb;

  always @(negedge clk) begin
    if (get_seen) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s: get result %0d with no expected item", "R5", count_out);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (count_out !== e) begin
          errors++;
          $display("FAIL %s: count_out=%0d expected %0d", t, count_out, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_cmd(input logic ld, input logic st, input logic sp,
                           input logic es, input logic ec, input logic [7:0] v);
    load_stb = ld; start_stb = st; stop_stb = sp;
    irq_en_set = es; irq_en_clr = ec; load_val = v;
    @(negedge clk);
    load_stb = 0; start_stb = 0; stop_stb = 0; irq_en_set = 0; irq_en_clr = 0;
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      cyc_stb = 1'b1;
      @(negedge clk);
      cyc_stb = 1'b0;
    end
  endtask

  task automatic get_expect(input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    get_stb = 1'b1;
    @(negedge clk);
    get_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_irq(input logic e, input string t);
    checks++;
    if (irq_req !== e) begin
      errors++;
      $display("FAIL %s: irq_req=%0b expected %0b", t, irq_req, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run hung, got 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (count_out !== 8'd0) begin
      errors++;
      $display("FAIL R1: count_out=%0d expected 0", count_out);
    end
    check_irq(1'b0, "R1");
    get_expect(8'd0, "R1");

    pulse_cmd(0, 0, 0, 1, 0, 8'd0);
    pulse_cmd(1, 0, 0, 0, 0, 8'd10);
    get_expect(8'd10, "R2");
    pulse_cmd(0, 1, 0, 0, 0, 8'd0);
    strobes(31);
    get_expect(8'd10, "R3");
    strobes(1);
    get_expect(8'd9, "R3");
    get_expect(8'd9, "R5");
    idle(50);
    get_expect(8'd9, "R4");
    strobes(64);
    get_expect(8'd7, "R4");

    pulse_cmd(0, 0, 1, 0, 0, 8'd0);
    strobes(40);
    get_expect(8'd7, "R8");

    pulse_cmd(1, 0, 0, 0, 0, 8'd2);
    pulse_cmd(0, 1, 0, 0, 0, 8'd0);
    strobes(63);
    get_expect(8'd1, "R4");
    check_irq(1'b0, "R6");
    strobes(1);
    check_irq(1'b1, "R6");
    get_expect(8'd2, "R6");
    strobes(32);
    get_expect(8'd1, "R6");

    pulse_cmd(0, 0, 0, 1, 1, 8'd0);
    check_irq(1'b0, "R7");
    strobes(32);
    get_expect(8'd2, "R7");
    pulse_cmd(0, 0, 0, 1, 0, 8'd0);
    check_irq(1'b1, "R7");

    pulse_cmd(0, 0, 1, 0, 0, 8'd0);
    check_irq(1'b0, "R8");
    get_expect(8'd2, "R8");

    pulse_cmd(1, 0, 0, 0, 0, 8'd5);
    pulse_cmd(0, 1, 0, 0, 0, 8'd0);
    strobes(20);
    pulse_cmd(1, 0, 0, 0, 0, 8'd9);
    strobes(12);
    get_expect(8'd8, "R9");

    pulse_cmd(0, 1, 1, 0, 0, 8'd0);
    strobes(40);
    get_expect(8'd8, "R8");

    pulse_cmd(1, 0, 0, 1, 0, 8'd1);
    pulse_cmd(0, 1, 0, 0, 0, 8'd0);
    strobes(32);
    check_irq(1'b1, "R6");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_irq(1'b0, "R1");
    checks++;
    if (count_out !== 8'd0) begin
      errors++;
      $display("FAIL R1: count_out=%0d expected 0 after reset", count_out);
    end

    idle(2);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5: %0d results pending, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule